// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns internal bus requests of a small 8-bit CPU core into external machine cycles on a multiplexed bus. The core presents a cycle kind, a 16-bit address, write data and a flag choosing a short or long opcode fetch. The sequencer steps through the T states of one machine cycle. It places the low address byte on the shared address/data lines during the first T state and then uses those lines for data. It pulses the address latch strobe and drives the read, write and interrupt-acknowledge strobes. It also holds the three status lines steady for the whole cycle.

The external side runs as separate output values and output enables, one enable per group of pins, so pad logic can build the three-state drivers. Slow devices stretch a cycle by holding READY low. Another bus master can ask for the bus with HOLD. The sequencer finishes the cycle in progress, releases every driven group and acknowledges. It takes the bus back after HOLD drops. Each clock period of the block is one T state. The block accepts a request only while idle, so one idle T state separates consecutive machine cycles.

Top module: `bus_cycle_seq`

## Requirements
- R1: Synchronous reset, also when applied in the middle of a cycle, leaves the sequencer idle with all output enables low, the strobes rd_n, wr_n and inta_n high, ale and hlda low, and req_ready high while hold_in is low.
- R2: In T1 of every cycle except halt, ale is high for that single T state, and ad_out carries address bits 7:0 with ad_oe high.
- R3: The status triple (io_m, s1, s0) encodes the kind as follows: fetch 0,1,1 (req_kind 0); memory read 0,1,0 (1); memory write 0,0,1 (2); I/O read 1,1,0 (3); I/O write 1,0,1 (4); interrupt acknowledge 1,1,1 (5); halt with io_m_oe low and s1,s0 at 0,0 (6).
- R4: The status lines become valid in T1 and do not change until the cycle ends.
- R5: Fetch, memory read and I/O read cycles drive rd_n low in T2, in every wait state and in T3, with ad_oe low. The byte on ad_in during T3 is returned on rsp_data with rsp_valid high in the following T state.
- R6: Write cycles drive write data on ad_out from T2 through T3 and hold wr_n low in T2 and in wait states. wr_n rises at the start of T3 while the data is still driven.
- R7: An interrupt acknowledge cycle pulls inta_n low with the timing a read uses for rd_n, returns the byte the same way, and keeps rd_n high.
- R8: In I/O cycles the port number, which is address bits 7:0, appears on both a_hi and ad_out during T1. In memory cycles a_hi carries address bits 15:8.
- R9: A fetch takes 4 T states when req_long is 0 and 6 when it is 1. After T3 the strobes are high and ad_oe is low, while the address high byte and the status stay driven.
- R10: Each rising clock edge that ends T2 or a wait state with ready_in low adds one wait state. Halt cycles ignore ready_in and last exactly 3 T states.
- R11: A HOLD raised during a cycle does not cut the cycle short. The bus is released only after the sequencer has passed through idle. While hlda is high, every output enable is low and no request is accepted.
- R12: After hold_in falls, hlda falls in the next T state and a pending request starts T1 in the T state after that.
- R13: A halt cycle drives no address, data, strobe or ALE, and tri-states io_m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T state per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code (see R3) |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Write data |
| req_long | input | 1 | Fetch takes 6 T states instead of 4 |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Read byte available |
| rsp_data | output | 8 | Byte captured at the end of T3 |
| ad_in | input | 8 | Shared address/data lines, input side |
| ad_out | output | 8 | Shared address/data lines, output value |
| ad_oe | output | 1 | Enable for ad_out |
| a_hi | output | 8 | High address byte |
| a_hi_oe | output | 1 | Enable for a_hi |
| ale | output | 1 | Address latch strobe, never floated |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| ctl_oe | output | 1 | Enable for rd_n, wr_n and inta_n |
| io_m | output | 1 | I/O (1) or memory (0) status |
| io_m_oe | output | 1 | Enable for io_m |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready_in | input | 1 | Device ready, low inserts wait states |
| hold_in | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |

## Verification
The hardest condition to reach from the ports is a HOLD that arrives in the middle of a cycle that READY is stretching. The handover must wait for both the wait states and the idle pass. The bench raises hold_in in T2 of a write with two wait states. It keeps checking the strobe and data timing cycle by cycle to the end of that write, then checks the release and the return. Every kind is also run with 0, 1 and 2 wait states and both fetch lengths. A reset is applied in the middle of a read.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  parameter int unsigned BUS_AW = 16;
  parameter int unsigned BUS_DW = 8;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_INTA  = 3'd5,
    K_HALT  = 3'd6
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TW, S_T3, S_TX, S_HOLD
  } tst_e;

  typedef struct packed {
    kind_e              kind;
    logic [BUS_AW-1:0]  addr;
    logic [BUS_DW-1:0]  wdata;
    logic               lng;
  } req_t;

  function automatic logic kind_reads(kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD) || (k == K_INTA);
  endfunction

  function automatic logic kind_writes(kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_io(kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction
endpackage

// File: rtl/bcs_status_enc.sv
module bcs_status_enc
  import bcs_pkg::*;
(
  input  kind_e kind,
  output logic  io_m,
  output logic  s1,
  output logic  s0,
  output logic  io_m_float
);
  always_comb begin
    io_m_float = 1'b0;
    unique case (kind)
      K_FETCH: {io_m, s1, s0} = 3'b011;
      K_MRD:   {io_m, s1, s0} = 3'b010;
      K_MWR:   {io_m, s1, s0} = 3'b001;
      K_IORD:  {io_m, s1, s0} = 3'b110;
      K_IOWR:  {io_m, s1, s0} = 3'b101;
      K_INTA:  {io_m, s1, s0} = 3'b111;
      default: begin
        {io_m, s1, s0} = 3'b000;
        io_m_float     = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bcs_tseq.sv
module bcs_tseq
  import bcs_pkg::*;
#(
  parameter int unsigned FETCH_SHORT = 4,
  parameter int unsigned FETCH_LONG  = 6
)(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  req_t req_in,
  input  logic ready_in,
  input  logic hold_in,
  output logic req_ready,
  output tst_e st_q,
  output tst_e st_d,
  output req_t cur_q,
  output req_t cur_d
);
  localparam int unsigned CW = (FETCH_LONG > 5) ? $clog2(FETCH_LONG - 3) : 1;
  localparam logic [CW-1:0] EXTRA_S = CW'(FETCH_SHORT - 4);
  localparam logic [CW-1:0] EXTRA_L = CW'(FETCH_LONG - 4);

  logic [CW-1:0] cnt_q, cnt_d;

  assign req_ready = (st_q == S_IDLE) && !hold_in;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: begin
        if (hold_in) st_d = S_HOLD;
        else if (req_valid) begin
          st_d  = S_T1;
          cur_d = req_in;
        end
      end
      S_T1: st_d = S_T2;
      S_T2, S_TW: begin
        if (cur_q.kind == K_HALT || ready_in) st_d = S_T3;
        else st_d = S_TW;
      end
      S_T3: begin
        if (cur_q.kind == K_FETCH) begin
          st_d  = S_TX;
          cnt_d = cur_q.lng ? EXTRA_L : EXTRA_S;
        end else st_d = S_IDLE;
      end
      S_TX: begin
        if (cnt_q == '0) st_d = S_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      S_HOLD: if (!hold_in) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cur_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  // R11: the hold state is entered only from idle
  p_hold_from_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HOLD) |-> ($past(st_q) == S_IDLE || $past(st_q) == S_HOLD));
  // R10: a halt cycle never waits
  p_halt_no_wait_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_TW) |-> (cur_q.kind != K_HALT));
endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned DW = BUS_DW
)(
  input  logic          clk,
  input  logic          rst,
  input  tst_e          st_d,
  input  kind_e         kind_d,
  input  logic [AW-1:0] addr_d,
  input  logic [DW-1:0] wdata_d,
  input  tst_e          st_q,
  input  kind_e         kind_q,
  input  logic [DW-1:0] ad_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic          a_hi_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          inta_n,
  output logic          ctl_oe,
  output logic          io_m,
  output logic          io_m_oe,
  output logic          s1,
  output logic          s0,
  output logic          hlda
);
  localparam int unsigned HW = AW - DW;

  logic enc_iom, enc_s1, enc_s0, enc_float;
  logic in_cyc, halt, data_ph, rd_ph, wr_ph;
  logic [HW-1:0] hi_sel;

  bcs_status_enc u_enc (
    .kind(kind_d), .io_m(enc_iom), .s1(enc_s1), .s0(enc_s0), .io_m_float(enc_float)
  );

  always_comb begin
    in_cyc  = (st_d == S_T1) || (st_d == S_T2) || (st_d == S_TW) ||
              (st_d == S_T3) || (st_d == S_TX);
    halt    = (kind_d == K_HALT);
    data_ph = (st_d == S_T2) || (st_d == S_TW) || (st_d == S_T3);
    rd_ph   = data_ph;
    wr_ph   = (st_d == S_T2) || (st_d == S_TW);
    hi_sel  = kind_io(kind_d) ? HW'(addr_d[DW-1:0]) : addr_d[AW-1:DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      a_hi      <= '0;
      a_hi_oe   <= 1'b0;
      ale       <= 1'b0;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      inta_n    <= 1'b1;
      ctl_oe    <= 1'b0;
      io_m      <= 1'b0;
      io_m_oe   <= 1'b0;
      s1        <= 1'b0;
      s0        <= 1'b0;
      hlda      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      ale     <= (st_d == S_T1) && !halt;
      ctl_oe  <= in_cyc && !halt;
      a_hi_oe <= in_cyc && !halt;
      if (in_cyc) a_hi <= hi_sel;
      io_m_oe <= in_cyc && !enc_float;
      io_m    <= in_cyc && enc_iom;
      s1      <= in_cyc && enc_s1;
      s0      <= in_cyc && enc_s0;
      hlda    <= (st_d == S_HOLD);
      if (st_d == S_T1 && !halt) begin
        ad_oe  <= 1'b1;
        ad_out <= addr_d[DW-1:0];
      end else if (data_ph && kind_writes(kind_d)) begin
        ad_oe  <= 1'b1;
        ad_out <= wdata_d;
      end else begin
        ad_oe  <= 1'b0;
      end
      rd_n   <= !(rd_ph && kind_reads(kind_d) && kind_d != K_INTA);
      inta_n <= !(rd_ph && kind_d == K_INTA);
      wr_n   <= !(wr_ph && kind_writes(kind_d));
      rsp_valid <= (st_q == S_T3) && kind_reads(kind_q);
      if ((st_q == S_T3) && kind_reads(kind_q)) rsp_data <= ad_in;
    end
  end

  // R2: the address strobe lasts one T state
  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  // R7: at most one strobe low at a time
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!rd_n, !wr_n, !inta_n}));
  // R5: shared lines float while a read strobe is low
  p_read_float_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !inta_n) |-> !ad_oe);
  // R6: write data still driven when the write strobe rises
  p_wr_data_held_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> ad_oe);
  // R11: everything released while the bus is granted
  p_hold_release_r11: assert property (@(posedge clk) disable iff (rst)
    hlda |-> !(ad_oe || a_hi_oe || ctl_oe || io_m_oe));
  // R4: status steady after T1 within a cycle
  p_status_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe && !ale) |-> $stable({io_m, s1, s0}));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int unsigned FETCH_SHORT = 4,
  parameter int unsigned FETCH_LONG  = 6
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_long,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic        a_hi_oe,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic        inta_n,
  output logic        ctl_oe,
  output logic        io_m,
  output logic        io_m_oe,
  output logic        s1,
  output logic        s0,
  input  logic        ready_in,
  input  logic        hold_in,
  output logic        hlda
);
  req_t req_in, cur_q, cur_d;
  tst_e st_q, st_d;

  always_comb begin
    req_in.kind  = kind_e'(req_kind);
    req_in.addr  = req_addr;
    req_in.wdata = req_wdata;
    req_in.lng   = req_long;
  end

  bcs_tseq #(.FETCH_SHORT(FETCH_SHORT), .FETCH_LONG(FETCH_LONG)) u_tseq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
    .ready_in(ready_in), .hold_in(hold_in), .req_ready(req_ready),
    .st_q(st_q), .st_d(st_d), .cur_q(cur_q), .cur_d(cur_d)
  );

  bcs_pins #(.AW(BUS_AW), .DW(BUS_DW)) u_pins (
    .clk(clk), .rst(rst), .st_d(st_d), .kind_d(cur_d.kind), .addr_d(cur_d.addr),
    .wdata_d(cur_d.wdata), .st_q(st_q), .kind_q(cur_q.kind), .ad_in(ad_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_hi(a_hi), .a_hi_oe(a_hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .inta_n(inta_n), .ctl_oe(ctl_oe), .io_m(io_m), .io_m_oe(io_m_oe),
    .s1(s1), .s0(s0), .hlda(hlda)
  );
endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_long = 1'b0;
  logic [7:0] ad_in = '0;
  logic ready_in = 1'b1;
  logic hold_in = 1'b0;
  logic req_ready, rsp_valid, ad_oe, a_hi_oe, ale, rd_n, wr_n, inta_n, ctl_oe;
  logic io_m, io_m_oe, s1, s0, hlda;
  logic [7:0] rsp_data, ad_out, a_hi;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .a_hi_oe(a_hi_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .ctl_oe(ctl_oe),
    .io_m(io_m), .io_m_oe(io_m_oe), .s1(s1), .s0(s0), .ready_in(ready_in),
    .hold_in(hold_in), .hlda(hlda)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(input int k);
    case (k)
      0: return 3'b011;
      1: return 3'b010;
      2: return 3'b001;
      3: return 3'b110;
      4: return 3'b101;
      5: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk_released(input string rq);
    chk({rq, " bus released"}, {ad_oe, a_hi_oe, ctl_oe, io_m_oe, ale}, 0);
    chk({rq, " strobes high"}, {rd_n, wr_n, inta_n}, 3'b111);
  endtask

  task automatic run_cycle(input int k, input logic [15:0] addr, input logic [7:0] wd,
                           input logic lng, input int nw, input logic [7:0] rdat,
                           input logic hold_mid);
    logic halt, io, rdk, wrk, rdp;
    logic [2:0] es;
    int ew;
    halt = (k == 6);
    io   = (k == 3 || k == 4);
    rdk  = (k == 0 || k == 1 || k == 3 || k == 5);
    rdp  = (k == 0 || k == 1 || k == 3);
    wrk  = (k == 2 || k == 4);
    es   = exp_stat(k);
    ew   = halt ? 0 : nw;
    @(negedge clk);
    chk("R1 req_ready idle", req_ready, 1);
    req_valid = 1'b1; req_kind = 3'(k); req_addr = addr; req_wdata = wd; req_long = lng;
    @(negedge clk);
    req_valid = 1'b0;
    // T1
    chk("R2 ale in T1", ale, !halt);
    chk("R2 ad_oe in T1", ad_oe, !halt);
    if (!halt) chk("R2 low address", ad_out, addr[7:0]);
    if (!halt) chk("R8 high byte", a_hi, io ? addr[7:0] : addr[15:8]);
    chk("R3 s1 s0", {s1, s0}, es[1:0]);
    chk("R3 io_m_oe", io_m_oe, !halt);
    if (!halt) chk("R3 io_m", io_m, es[2]);
    chk("R13 strobes idle in T1", {rd_n, wr_n, inta_n}, 3'b111);
    if (halt) chk("R13 halt no drive", {a_hi_oe, ctl_oe}, 0);
    @(negedge clk);
    for (int w = 0; w <= ew; w++) begin
      if (hold_mid && w == 0) hold_in = 1'b1;
      chk("R2 ale low after T1", ale, 0);
      chk("R4 status steady", {io_m, s1, s0}, {halt ? 1'b0 : es[2], es[1:0]});
      chk("R10 read strobe in T2 or wait", rd_n, !rdp);
      chk("R7 inta strobe", inta_n, !(k == 5));
      chk("R10 write strobe in T2 or wait", wr_n, !wrk);
      if (wrk) chk("R6 write data", ad_out, wd);
      chk("R5 data lines direction", ad_oe, wrk);
      if (halt) chk("R13 halt quiet", {ctl_oe, a_hi_oe, io_m_oe}, 0);
      ready_in = halt ? 1'b0 : (w == ew);
      @(negedge clk);
    end
    // T3
    chk("R5 read strobe in T3", rd_n, !rdp);
    chk("R7 inta in T3", inta_n, !(k == 5));
    chk("R6 wr_n high in T3", wr_n, 1);
    chk("R6 data held in T3", ad_oe, wrk);
    if (wrk) chk("R6 data value in T3", ad_out, wd);
    chk("R4 status steady T3", {s1, s0}, es[1:0]);
    ad_in = rdat;
    ready_in = 1'b1;
    @(negedge clk);
    if (k == 0) begin
      for (int j = 0; j < (lng ? 3 : 1); j++) begin
        chk("R9 strobes high after T3", {rd_n, wr_n, inta_n}, 3'b111);
        chk("R9 lines float after T3", ad_oe, 0);
        chk("R9 high byte and status driven", {a_hi_oe, ctl_oe, io_m, s1, s0}, 5'b11011);
        if (j == 0) begin
          chk("R5 fetch rsp_valid", rsp_valid, 1);
          chk("R5 fetch rsp_data", rsp_data, rdat);
        end
        @(negedge clk);
      end
    end else begin
      chk("R5 rsp_valid", rsp_valid, rdk);
      if (rdk) chk("R5 rsp_data", rsp_data, rdat);
    end
    chk_released("R9 R10 cycle end");
    chk("R11 no hlda at cycle end", hlda, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_released("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk_released("R1 after reset");
    chk("R1 hlda after reset", hlda, 0);
    chk("R1 req_ready after reset", req_ready, 1);

    for (int k = 0; k <= 6; k++)
      for (int nw = 0; nw <= 2; nw++)
        for (int l = 0; l <= 1; l++) begin
          logic [15:0] a;
          a = 16'h3C5A + 16'h1111 * 16'(k) + 16'h0203 * 16'(nw) + 16'h0080 * 16'(l);
          run_cycle(k, a, a[7:0] ^ 8'hA5, l[0], nw, ~a[15:8] + 8'(nw), 1'b0);
        end

    // R11/R12: hold raised in T2 of a stretched write
    run_cycle(2, 16'hBEEF, 8'h5C, 1'b0, 2, 8'h00, 1'b1);
    @(negedge clk);
    chk("R11 hlda after stretched cycle", hlda, 1);
    chk_released("R11 during hold");
    chk("R11 no accept during hold", req_ready, 0);
    hold_in = 1'b0;
    @(negedge clk);
    chk("R12 hlda falls", hlda, 0);
    chk("R12 accept after hold", req_ready, 1);

    // R11/R12: hold and request together in idle
    hold_in = 1'b1; req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h7788;
    #1 chk("R11 request refused with hold", req_ready, 0);
    @(negedge clk);
    chk("R11 hold wins over request", {hlda, ale}, 2'b10);
    hold_in = 1'b0;
    @(negedge clk);
    chk("R12 hlda low, not yet started", {hlda, ale}, 2'b00);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 request starts T1", ale, 1);
    chk("R12 started address", ad_out, 8'h88);
    repeat (3) @(negedge clk);
    chk_released("R12 cycle after hold done");

    // R1: reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h4321;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 read in progress", rd_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk_released("R1 mid-cycle reset");
    rst = 1'b0;
    @(negedge clk);
    chk_released("R1 idle after mid reset");
    chk("R1 ready after mid reset", req_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule